// File: doc/BRIEF.md
# Dual-Mask Interrupt Controller

This block gathers up to 32 level-sensitive interrupt lines into a single raw status word and drives two level outputs from it: a normal interrupt and a fast interrupt. Each output has its own enable mask, so any source can be routed to the normal line, the fast line, both, or neither. Software never writes a mask directly. Each mask has one register that sets bits where a 1 is written and another that clears bits where a 1 is written. Line 0 can also be raised from software: a software flag is ORed into raw bit 0 alongside external line 0.

Access is through a simple 32-bit register port with word offsets. Reads are combinational within the access cycle. A write takes effect at the clock edge that samples it. Both outputs are registered, so they follow any change of the masked status one clock later. Offsets that are write-only return zero when read. Writes to read-only or unmapped offsets are dropped.

Top module: `irq_fiq_ctrl`

## Requirements
- R1: After reset, both enable masks and the software flag are zero, `irq_o` and `fiq_o` are low, and reads of offsets 2, 10 and 4 return zero.
- R2: Reads of offset 1 and of offset 9 both return the raw word. Its bit 0 is external line 0 ORed with the software flag. Every other bit i follows `src_i[i]`.
- R3: A read of offset 0 returns the raw word ANDed with the normal mask. A read of offset 8 returns the raw word ANDed with the fast mask.
- R4: A write to offset 2 ORs the data into the normal mask, and a write to offset 10 ORs the data into the fast mask. Reads of offsets 2 and 10 return the normal and fast masks.
- R5: A write to offset 3 clears each normal-mask bit where the data has a 1, and a write to offset 11 does the same for the fast mask. Mask bits where the data has a 0 keep their value.
- R6: A write to offset 4 with data bit 0 set raises the software flag. A write to offset 5 with data bit 0 set lowers it. Either write with data bit 0 clear leaves the flag unchanged.
- R7: A read of offset 4 returns raw bit 0 in bit 0, with all other bits zero.
- R8: `irq_o` equals the OR of the normal masked status and `fiq_o` equals the OR of the fast masked status, each sampled at the previous clock edge.
- R9: Reads of offsets 3, 5 and 11, and of unmapped offsets, return zero.
- R10: Writes to offsets 0, 1, 8 and 9, and to unmapped offsets, leave both masks and the software flag unchanged.
- R11: A write to one mask's set or clear register never changes the other mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Level-sensitive interrupt lines |
| sel_i | input | 1 | Register access valid this cycle |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Word offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid while a read is selected |
| irq_o | output | 1 | Normal interrupt, registered |
| fiq_o | output | 1 | Fast interrupt, registered |

## Verification
The bench checks partial set and clear patterns against bits that are already set. A design that assigns the mask instead of ORing or ANDing into it would lose the bits that should have been kept. It writes all-ones to the read-only and unmapped offsets and then reads back every piece of state, which catches decode aliasing between the two channels or onto the software registers. Software-flag writes with bit 0 clear but other bits set expose a flag that reacts to the wrong bit. Output checks are made both before and after the clock edge that follows a stimulus, so an output that is combinational or two cycles late is reported.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned N_CH   = 2;   // 0: normal, 1: fast
  localparam int unsigned CH_STRIDE = 8;

  // per-channel register slots, relative to channel base
  localparam int unsigned SLOT_STAT = 0;
  localparam int unsigned SLOT_RAW  = 1;
  localparam int unsigned SLOT_ESET = 2;
  localparam int unsigned SLOT_ECLR = 3;

  localparam logic [ADDR_W-1:0] OFF_SW_SET = 4'd4;
  localparam logic [ADDR_W-1:0] OFF_SW_CLR = 4'd5;

  function automatic logic [ADDR_W-1:0] ch_off(input int unsigned ch, input int unsigned slot);
    return ADDR_W'(ch * CH_STRIDE + slot);
  endfunction
endpackage

// File: rtl/irqc_mask_bank.sv
module irqc_mask_bank #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    mask_q <= '0;
    else if (set_i) mask_q <= mask_q | wdata_i;
    else if (clr_i) mask_q <= mask_q & ~wdata_i;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/irqc_swint.sv
module irqc_swint (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic bit0_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              flag_q <= 1'b0;
    else if (set_i && bit0_i) flag_q <= 1'b1;
    else if (clr_i && bit0_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/irqc_outreg.sv
module irqc_outreg #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] status_i,
  output logic         line_o
);
  logic line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) line_q <= 1'b0;
    else         line_q <= |status_i;
  end

  assign line_o = line_q;
endmodule

// File: rtl/irq_fiq_ctrl.sv
module irq_fiq_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N_SRC  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              fiq_o
);
  logic              wr_en, rd_en;
  logic              sw_flag;
  logic [DATA_W-1:0] raw_w;
  logic [DATA_W-1:0] mask_q [N_CH];
  logic [DATA_W-1:0] stat_w [N_CH];
  logic [N_CH-1:0]   line_w;

  assign wr_en = sel_i &  wr_i;
  assign rd_en = sel_i & ~wr_i;

  // raw word: line 0 also carries the software flag
  always_comb begin
    raw_w = '0;
    raw_w[N_SRC-1:0] = src_i;
    raw_w[0] = src_i[0] | sw_flag;
  end

  irqc_swint u_sw (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (wr_en && addr_i == OFF_SW_SET),
    .clr_i  (wr_en && addr_i == OFF_SW_CLR),
    .bit0_i (wdata_i[0]),
    .flag_o (sw_flag)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] OffSet = ch_off(c, SLOT_ESET);
    localparam logic [ADDR_W-1:0] OffClr = ch_off(c, SLOT_ECLR);

    irqc_mask_bank #(.W(DATA_W)) u_mask (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_i   (wr_en && addr_i == OffSet),
      .clr_i   (wr_en && addr_i == OffClr),
      .wdata_i (wdata_i),
      .mask_o  (mask_q[c])
    );

    assign stat_w[c] = raw_w & mask_q[c];

    irqc_outreg #(.W(DATA_W)) u_out (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .status_i (stat_w[c]),
      .line_o   (line_w[c])
    );
  end

  assign irq_o = line_w[0];
  assign fiq_o = line_w[1];

  // read mux; write-only and unmapped offsets fall through to zero
  always_comb begin
    rdata_o = '0;
    if (rd_en) begin
      for (int c = 0; c < N_CH; c++) begin
        if (addr_i == ch_off(c, SLOT_STAT)) rdata_o = stat_w[c];
        if (addr_i == ch_off(c, SLOT_RAW))  rdata_o = raw_w;
        if (addr_i == ch_off(c, SLOT_ESET)) rdata_o = mask_q[c];
      end
      if (addr_i == OFF_SW_SET) rdata_o = {{(DATA_W-1){1'b0}}, raw_w[0]};
    end
  end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel_i,
  input logic              wr_i,
  input logic [3:0]        addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [DATA_W-1:0] raw_i,
  input logic [DATA_W-1:0] irq_mask_i,
  input logic [DATA_W-1:0] fiq_mask_i,
  input logic              sw_i,
  input logic              irq_o,
  input logic              fiq_o
);
  logic wr_en, rd_en, ro_wr, wo_rd;
  assign wr_en = sel_i & wr_i;
  assign rd_en = sel_i & ~wr_i;
  assign ro_wr = wr_en && (addr_i == 4'd0 || addr_i == 4'd1 || addr_i == 4'd8 ||
                           addr_i == 4'd9 || addr_i == 4'd6 || addr_i == 4'd7 ||
                           addr_i >= 4'd12);
  assign wo_rd = rd_en && (addr_i == 4'd3 || addr_i == 4'd5 || addr_i == 4'd11);

  a_r4_irq_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && addr_i == 4'd2) |=> ((irq_mask_i & $past(wdata_i)) == $past(wdata_i)));

  a_r5_fiq_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && addr_i == 4'd11) |=> ((fiq_mask_i & $past(wdata_i)) == '0));

  a_r6_sw_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && addr_i == 4'd5 && wdata_i[0]) |=> !sw_i);

  a_r8_irq_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> (irq_o == $past(|(raw_i & irq_mask_i))));

  a_r8_fiq_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> (fiq_o == $past(|(raw_i & fiq_mask_i))));

  a_r9_wo_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wo_rd |-> (rdata_o == '0));

  a_r10_ro_write_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ro_wr |=> ($stable(irq_mask_i) && $stable(fiq_mask_i) && $stable(sw_i)));

  a_r11_irq_write_keeps_fiq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && (addr_i == 4'd2 || addr_i == 4'd3)) |=> $stable(fiq_mask_i));
endmodule

bind irq_fiq_ctrl irqc_checker #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sel_i      (sel_i),
  .wr_i       (wr_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .raw_i      (raw_w),
  .irq_mask_i (mask_q[0]),
  .fiq_mask_i (mask_q[1]),
  .sw_i       (sw_flag),
  .irq_o      (irq_o),
  .fiq_o      (fiq_o)
);

// File: tb/irq_fiq_ctrl_tb.sv
`timescale 1ns/1ps
module irq_fiq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, fiq;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  irq_fiq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .sel_i(sel), .wr_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .fiq_o(fiq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0; wdata = '0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b0; addr = a;
    #1 d = rdata;
    sel = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 irq_o", {31'b0, irq}, 0);
    chk("R1 fiq_o", {31'b0, fiq}, 0);
    rd_reg(4'd2, d);  chk("R1 irq mask", d, 0);
    rd_reg(4'd10, d); chk("R1 fiq mask", d, 0);
    rd_reg(4'd4, d);  chk("R1 sw flag", d, 0);
  endtask

  task automatic t_raw;
    logic [31:0] d;
    src = 32'hA5C3_0F01;
    rd_reg(4'd1, d); chk("R2 raw off1", d, 32'hA5C3_0F01);
    rd_reg(4'd9, d); chk("R2 raw off9", d, 32'hA5C3_0F01);
    src = 32'h8000_0002;
    rd_reg(4'd1, d); chk("R2 raw pattern2", d, 32'h8000_0002);
  endtask

  task automatic t_masks;
    logic [31:0] d;
    wr_reg(4'd2, 32'h00F0_00F0);
    wr_reg(4'd2, 32'h0000_0F00);
    rd_reg(4'd2, d);  chk("R4 irq set or", d, 32'h00F0_0FF0);
    rd_reg(4'd10, d); chk("R11 fiq untouched by irq set", d, 0);
    wr_reg(4'd3, 32'h00F0_0030);
    rd_reg(4'd2, d);  chk("R5 irq clr partial", d, 32'h0000_0FC0);
    wr_reg(4'd10, 32'hFFFF_0000);
    wr_reg(4'd11, 32'h0F0F_0000);
    rd_reg(4'd10, d); chk("R5 fiq clr partial", d, 32'hF0F0_0000);
    rd_reg(4'd2, d);  chk("R11 irq untouched by fiq", d, 32'h0000_0FC0);
  endtask

  task automatic t_masked_stat;
    logic [31:0] d;
    src = 32'h1234_5678;
    rd_reg(4'd0, d); chk("R3 irq stat", d, 32'h1234_5678 & 32'h0000_0FC0);
    rd_reg(4'd8, d); chk("R3 fiq stat", d, 32'h1234_5678 & 32'hF0F0_0000);
  endtask

  task automatic t_lines;
    src = '0;
    @(negedge clk); @(negedge clk);
    chk("R8 irq idle", {31'b0, irq}, 0);
    chk("R8 fiq idle", {31'b0, fiq}, 0);
    src = 32'h0000_0040;          // irq mask only
    #1 chk("R8 irq not yet", {31'b0, irq}, 0);
    @(negedge clk);
    chk("R8 irq one cycle", {31'b0, irq}, 1);
    chk("R8 fiq stays low", {31'b0, fiq}, 0);
    src = 32'h0010_0000;          // fiq mask only
    @(negedge clk);
    chk("R8 irq drops", {31'b0, irq}, 0);
    chk("R8 fiq rises", {31'b0, fiq}, 1);
    wr_reg(4'd11, 32'h0010_0000);
    chk("R8 fiq held until next edge", {31'b0, fiq}, 1);
    @(negedge clk);
    chk("R8 fiq after mask clr", {31'b0, fiq}, 0);
    src = '0;
  endtask

  task automatic t_soft;
    logic [31:0] d;
    src = 32'h8000_0000;
    wr_reg(4'd4, 32'hFFFF_FFFE);
    rd_reg(4'd4, d); chk("R6 set bit0 clear ignored", d, 0);
    wr_reg(4'd4, 32'h0000_0001);
    rd_reg(4'd4, d); chk("R7 sw read bit0 only", d, 1);
    rd_reg(4'd1, d); chk("R2 raw with sw", d, 32'h8000_0001);
    wr_reg(4'd5, 32'hFFFF_FFFE);
    rd_reg(4'd4, d); chk("R6 clr bit0 clear ignored", d, 1);
    wr_reg(4'd5, 32'h0000_0001);
    rd_reg(4'd4, d); chk("R6 sw cleared", d, 0);
    src = 32'h0000_0001;
    rd_reg(4'd4, d); chk("R7 sw read ext line0", d, 1);
    src = '0;
  endtask

  task automatic t_bad_read;
    logic [31:0] d;
    wr_reg(4'd4, 32'h1);
    rd_reg(4'd3, d);  chk("R9 read off3", d, 0);
    rd_reg(4'd5, d);  chk("R9 read off5", d, 0);
    rd_reg(4'd11, d); chk("R9 read off11", d, 0);
    rd_reg(4'd6, d);  chk("R9 read off6", d, 0);
    rd_reg(4'd15, d); chk("R9 read off15", d, 0);
  endtask

  task automatic t_bad_write;
    logic [31:0] d;
    wr_reg(4'd0, 32'hFFFF_FFFF);
    wr_reg(4'd1, 32'hFFFF_FFFF);
    wr_reg(4'd8, 32'hFFFF_FFFF);
    wr_reg(4'd9, 32'hFFFF_FFFF);
    wr_reg(4'd7, 32'hFFFF_FFFF);
    wr_reg(4'd12, 32'hFFFF_FFFF);
    rd_reg(4'd2, d);  chk("R10 irq mask kept", d, 32'h0000_0FC0);
    rd_reg(4'd10, d); chk("R10 fiq mask kept", d, 32'hF0E0_0000);
    rd_reg(4'd4, d);  chk("R10 sw flag kept", d, 1);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_raw;
    t_masks;
    t_masked_stat;
    t_lines;
    t_soft;
    t_bad_read;
    t_bad_write;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule